// File: doc/BRIEF.md
# Eight-Bit ALU with Status Flags

This block is the arithmetic core of a small accumulator-style processor. It holds an internal working value (the accumulator) and three status flags: carry, nibble carry and zero. Each issued operation combines the accumulator with a second operand. That operand is either a byte read from the register file or an immediate constant carried by the instruction. The block produces an 8-bit result and updates the flags that belong to the operation.

A destination select decides where the result goes. It either replaces the accumulator, or it leaves the block on a one-cycle write port toward the register file. In that second case the accumulator keeps its value. Register file storage, addressing and instruction decode sit outside the block.

The accumulator cannot be reached through the register file port. It is only visible on its own output.

All state is registered. An operation is sampled on a rising edge while `op_valid` is high. Its results are visible on the outputs right after that same edge.

Top module: `alu8_unit`

## Requirements
- R1: While `rst_n` is low and after its release, the accumulator reads 0x00, carry, nibble carry and zero read 0, and `file_wr_en` is 0.
- R2: Operation code 3'b000 (add) produces (accumulator + operand) mod 256. Carry is the carry out of bit 7, nibble carry is the carry out of bit 3, and zero is set when the result is 0x00.
- R3: Operation code 3'b001 (subtract) produces (operand − accumulator) mod 256. Carry is 1 when no borrow occurs (operand ≥ accumulator). Nibble carry is 1 when the low nibble causes no borrow. Zero is set when the result is 0x00.
- R4: Operation codes 3'b010 (AND), 3'b011 (OR), 3'b100 (XOR) and 3'b111 (bitwise complement of the operand) update only the zero flag. Carry and nibble carry keep their values.
- R5: Operation code 3'b101 (rotate left through carry) produces {operand[6:0], old carry} and loads carry from operand bit 7. Nibble carry and zero keep their values.
- R6: Operation code 3'b110 (rotate right through carry) produces {old carry, operand[7:1]} and loads carry from operand bit 0. Nibble carry and zero keep their values.
- R7: The second operand is `imm` when `use_imm` is 1 and `file_in` when it is 0.
- R8: With `dest_file` = 0 the accumulator takes the result at the sampling edge and `file_wr_en` stays 0. With `dest_file` = 1, `file_wr_en` is 1 for exactly the cycle after the edge with the result on `file_wr_data`, and the accumulator is unchanged.
- R9: While `op_valid` is 0 the accumulator and all three flags hold, and `file_wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Issue an operation on this edge |
| op_code | input | 3 | Operation selector (encodings in R2–R6) |
| use_imm | input | 1 | 1: operand from `imm`; 0: operand from `file_in` |
| imm | input | 8 | Immediate operand |
| file_in | input | 8 | Operand read from the register file |
| dest_file | input | 1 | 1: result to the file write port; 0: result to the accumulator |
| w_out | output | 8 | Current accumulator value |
| carry | output | 1 | Carry / no-borrow flag |
| dcarry | output | 1 | Nibble carry / no-nibble-borrow flag |
| zero | output | 1 | Zero flag |
| file_wr_en | output | 1 | One-cycle write strobe toward the register file |
| file_wr_data | output | 8 | Result carried by the write strobe |

## Verification
Every result is due one clock after its issue. The accumulator, the flags and the write strobe all change on the same rising edge that samples `op_valid`. Nothing in the block adds latency beyond that edge.

The bench drives each operation on a falling edge. It compares every output against its behavioural model on the next falling edge, so each clock yields one comparison. The write strobe gets special attention. Because it lasts only one cycle, the same comparison also confirms that the strobe is gone on the following clock.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_RLC = 3'd5,
        OP_RRC = 3'd6,
        OP_NOT = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic dc;
        logic z;
    } flag_s;

    typedef struct packed {
        logic upd_c;
        logic upd_dc;
        logic upd_z;
    } flag_mask_s;
endpackage

// File: rtl/alu8_datapath.sv
module alu8_datapath
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] opnd,
    input  logic             carry_in,
    output logic [WIDTH-1:0] res,
    output flag_s            flg,
    output flag_mask_s       mask
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] addend;
    logic             cin;
    logic [WIDTH:0]   sum_full;
    logic [HALF:0]    sum_low;

    // subtraction: operand + ~acc + 1, flags straight from that sum
    always_comb begin
        addend   = (op == OP_SUB) ? ~acc : acc;
        cin      = (op == OP_SUB);
        sum_full = {1'b0, opnd} + {1'b0, addend} + {{WIDTH{1'b0}}, cin};
        sum_low  = {1'b0, opnd[HALF-1:0]} + {1'b0, addend[HALF-1:0]}
                 + {{HALF{1'b0}}, cin};
    end

    always_comb begin
        res     = '0;
        flg.c   = carry_in;
        flg.dc  = sum_low[HALF];
        mask    = '{upd_c: 1'b0, upd_dc: 1'b0, upd_z: 1'b1};
        unique case (op)
            OP_ADD, OP_SUB: begin
                res   = sum_full[WIDTH-1:0];
                flg.c = sum_full[WIDTH];
                mask  = '{upd_c: 1'b1, upd_dc: 1'b1, upd_z: 1'b1};
            end
            OP_AND: res = acc & opnd;
            OP_OR:  res = acc | opnd;
            OP_XOR: res = acc ^ opnd;
            OP_NOT: res = ~opnd;
            OP_RLC: begin
                res   = {opnd[WIDTH-2:0], carry_in};
                flg.c = opnd[WIDTH-1];
                mask  = '{upd_c: 1'b1, upd_dc: 1'b0, upd_z: 1'b0};
            end
            OP_RRC: begin
                res   = {carry_in, opnd[WIDTH-1:1]};
                flg.c = opnd[0];
                mask  = '{upd_c: 1'b1, upd_dc: 1'b0, upd_z: 1'b0};
            end
            default: res = '0;
        endcase
        flg.z = (res == '0);
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_en,
    input  flag_s      nxt,
    input  flag_mask_s mask,
    output flag_s      cur
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (upd_en) begin
            if (mask.upd_c)  cur.c  <= nxt.c;
            if (mask.upd_dc) cur.dc <= nxt.dc;
            if (mask.upd_z)  cur.z  <= nxt.z;
        end
    end
endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic             use_imm,
    input  logic [WIDTH-1:0] imm,
    input  logic [WIDTH-1:0] file_in,
    input  logic             dest_file,
    output logic [WIDTH-1:0] w_out,
    output logic             carry,
    output logic             dcarry,
    output logic             zero,
    output logic             file_wr_en,
    output logic [WIDTH-1:0] file_wr_data
);
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] opnd;
    logic [WIDTH-1:0] res;
    flag_s            flg_nxt;
    flag_s            flg_q;
    flag_mask_s       mask;

    assign opnd = use_imm ? imm : file_in;

    alu8_datapath #(.WIDTH(WIDTH)) u_dp (
        .op       (alu_op_e'(op_code)),
        .acc      (acc_q),
        .opnd     (opnd),
        .carry_in (flg_q.c),
        .res      (res),
        .flg      (flg_nxt),
        .mask     (mask)
    );

    alu8_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_en (op_valid),
        .nxt    (flg_nxt),
        .mask   (mask),
        .cur    (flg_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q        <= '0;
            file_wr_en   <= 1'b0;
            file_wr_data <= '0;
        end else begin
            file_wr_en <= op_valid && dest_file;
            if (op_valid && dest_file) file_wr_data <= res;
            if (op_valid && !dest_file) acc_q <= res;
        end
    end

    assign w_out  = acc_q;
    assign carry  = flg_q.c;
    assign dcarry = flg_q.dc;
    assign zero   = flg_q.z;
endmodule

// File: rtl/alu8_unit_chk.sv
module alu8_unit_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [2:0]       op_code,
    input logic             dest_file,
    input logic [WIDTH-1:0] w_out,
    input logic             carry,
    input logic             dcarry,
    input logic             zero,
    input logic             file_wr_en,
    input logic [WIDTH-1:0] file_wr_data
);
    logic is_logic, is_rot;
    assign is_logic = (op_code == 3'd2) || (op_code == 3'd3) ||
                      (op_code == 3'd4) || (op_code == 3'd7);
    assign is_rot   = (op_code == 3'd5) || (op_code == 3'd6);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(w_out) && $stable(carry) && $stable(dcarry)
                      && $stable(zero) && !file_wr_en);

    // R8
    file_dest_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && dest_file) |=> file_wr_en && $stable(w_out));

    // R8
    acc_dest_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !dest_file) |=> !file_wr_en);

    // R4
    logic_keeps_carries_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_logic) |=> $stable(carry) && $stable(dcarry));

    // R5
    rotate_keeps_dc_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_rot) |=> $stable(dcarry) && $stable(zero));

    // R2
    zero_matches_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !is_rot) |=>
            zero == ($past(dest_file) ? (file_wr_data == '0) : (w_out == '0)));
endmodule

bind alu8_unit alu8_unit_chk #(.WIDTH(WIDTH)) u_alu8_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .dest_file    (dest_file),
    .w_out        (w_out),
    .carry        (carry),
    .dcarry       (dcarry),
    .zero         (zero),
    .file_wr_en   (file_wr_en),
    .file_wr_data (file_wr_data)
);

// File: tb/test_alu8_unit.sv
module test_alu8_unit;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [2:0] op_code;
    logic       use_imm;
    logic [7:0] imm;
    logic [7:0] file_in;
    logic       dest_file;
    logic [7:0] w_out;
    logic       carry, dcarry, zero;
    logic       file_wr_en;
    logic [7:0] file_wr_data;

    always #2 clk = ~clk;

    alu8_unit i_alu8_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .use_imm(use_imm), .imm(imm), .file_in(file_in), .dest_file(dest_file),
        .w_out(w_out), .carry(carry), .dcarry(dcarry), .zero(zero),
        .file_wr_en(file_wr_en), .file_wr_data(file_wr_data)
    );

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    int  mw = 0, mc = 0, mdc = 0, mz = 0;
    int  exp_we = 0, exp_wd = 0;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk(tag, "w_out", int'(w_out), mw);
        chk(tag, "carry", int'(carry), mc);
        chk(tag, "dcarry", int'(dcarry), mdc);
        chk(tag, "zero", int'(zero), mz);
        chk(tag, "file_wr_en", int'(file_wr_en), exp_we);
        if (exp_we == 1) chk(tag, "file_wr_data", int'(file_wr_data), exp_wd);
    endtask

    // called at a falling edge; returns at the next falling edge after comparing
    task automatic step(bit v, int op, bit ui, int imm_v, int fin, bit dst, string tag);
        int b, r;
        op_valid  = v;
        op_code   = op[2:0];
        use_imm   = ui;
        imm       = imm_v[7:0];
        file_in   = fin[7:0];
        dest_file = dst;
        b = ui ? imm_v : fin;
        r = 0;
        exp_we = 0;
        if (v) begin
            case (op)
                0: begin
                    r = mw + b; mc = (r > 255); mdc = (((mw & 15) + (b & 15)) > 15);
                    r = r & 255; mz = (r == 0);
                end
                1: begin
                    r = (b - mw) & 255; mc = (b >= mw); mdc = ((b & 15) >= (mw & 15));
                    mz = (r == 0);
                end
                2: begin r = mw & b; mz = (r == 0); end
                3: begin r = mw | b; mz = (r == 0); end
                4: begin r = mw ^ b; mz = (r == 0); end
                7: begin r = (~b) & 255; mz = (r == 0); end
                5: begin r = ((b << 1) | mc) & 255; mc = (b >> 7) & 1; end
                default: begin r = (b >> 1) | (mc << 7); mc = b & 1; end
            endcase
            if (dst) begin exp_we = 1; exp_wd = r; end
            else mw = r;
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        rst_n = 1'b0; op_valid = 0; op_code = 0; use_imm = 0;
        imm = 0; file_in = 0; dest_file = 0;
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");

        // R2 add: load acc, nibble carry, full carry with zero
        step(1, 0, 1, 8'h3C, 8'h00, 0, "R2");
        step(1, 0, 1, 8'h0C, 8'h00, 0, "R2");   // 3C+0C = 48, DC=1
        step(1, 0, 0, 8'h00, 8'hB8, 0, "R2");   // 48+B8 = 00, C=1 Z=1
        step(1, 0, 1, 8'h80, 8'h00, 0, "R2");   // acc 80
        step(1, 0, 1, 8'h80, 8'h00, 1, "R2");   // 80+80 -> file 00
        // R3 subtract
        step(1, 1, 1, 8'h85, 8'h00, 0, "R3");   // 85-80 = 05, no borrow
        step(1, 1, 1, 8'h03, 8'h00, 0, "R3");   // 03-05 borrow
        step(1, 1, 0, 8'h00, 8'hFE, 1, "R3");   // FE-FE = 0 -> file
        step(1, 1, 1, 8'h10, 8'h00, 1, "R3");   // 10-FE nibble borrow
        // R4 logic leaves C/DC
        step(1, 0, 1, 8'hFF, 8'h00, 0, "R4");   // FE+FF sets carry
        step(1, 2, 1, 8'h01, 8'h00, 0, "R4");   // FD & 01
        step(1, 3, 0, 8'h00, 8'h00, 1, "R4");
        step(1, 4, 1, 8'h01, 8'h00, 0, "R4");
        step(1, 7, 1, 8'hFF, 8'h00, 1, "R4");
        // R5 / R6 rotates through carry
        step(1, 5, 1, 8'h81, 8'h00, 0, "R5");
        step(1, 5, 1, 8'h00, 8'h00, 1, "R5");
        step(1, 6, 1, 8'h01, 8'h00, 0, "R6");
        step(1, 6, 0, 8'h00, 8'h02, 1, "R6");
        // R7 operand select: file_in ignored with use_imm=1, and the reverse
        step(1, 3, 1, 8'h10, 8'hEE, 0, "R7");
        step(1, 3, 0, 8'hEE, 8'h20, 0, "R7");
        // R9 idle hold and no write strobe
        step(0, 0, 1, 8'h55, 8'h55, 1, "R9");
        step(0, 1, 0, 8'h55, 8'h55, 0, "R9");
        // R8 back-to-back file writes then acc
        step(1, 0, 1, 8'h01, 8'h00, 1, "R8");
        step(1, 0, 1, 8'h02, 8'h00, 1, "R8");
        step(1, 0, 1, 8'h03, 8'h00, 0, "R8");
        step(0, 0, 0, 8'h00, 8'h00, 0, "R8");
        // mixed stimulus
        for (int i = 0; i < 400; i++) begin
            int rv;
            rv = $urandom;
            step(rv[0] | rv[1], rv[4:2], rv[5], int'($urandom & 255),
                 int'($urandom & 255), rv[6], "R8");
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule